// File: doc/BRIEF.md
# Edge Interrupt Detector Aggregator

This block watches a word of already-synchronized general-purpose input pins and turns selected transitions on them into latched interrupt requests. Each pin has two independent enables, one for low-to-high transitions and one for high-to-low transitions. Each enable mask is changed only through a pair of strobe registers. Writing ones to the "set" register turns the chosen bits on, and writing ones to the "clear" register turns them off, so software never has to do a read-modify-write. A pin with both enables on reports either transition.

A detected transition sets a sticky bit in a pending-status register. Software acknowledges a bit by writing a one to that bit position. The pending word is split into banks of 16 pins. Each bank drives one level-type request line, which stays high while any of its pending bits is set and the bank's gate bit is on. Bank 0 covers pins 15:0 and bank 1 covers pins 31:16. The bank gate register sits at byte offset 0x08, and its bit n gates bank n.

Top module: `gpio_edge_irq`

## Requirements
- R1: After reset, both enable masks, the pending-status register and the bank gate register read as zero, and every bank line is low.
- R2: A write to the rising-set register (offset 0x10) turns on the rising enable of every bit written as 1 and leaves bits written as 0 unchanged. Reading either offset 0x10 or offset 0x14 returns the current rising enable mask.
- R3: A write to the rising-clear register (offset 0x14) turns off the rising enable of every bit written as 1 and leaves the other bits unchanged.
- R4: The falling enable mask behaves the same way, through the set register at offset 0x18 and the clear register at offset 0x1C. Reading either offset returns the mask.
- R5: A pin that is low at one clock edge and high at the next sets its pending bit at that second edge if its rising enable is on. A high-to-low change does the same if the falling enable is on. A change on a pin whose matching enable is off sets nothing.
- R6: A pin with both enables on sets its pending bit on either kind of transition.
- R7: A write to the pending-status register (offset 0x20) clears each bit written as 1 and leaves bits written as 0 unchanged. A read of offset 0x20 returns the pending bits.
- R8: If a new transition and a write-one-to-clear hit the same bit at the same clock edge, the bit stays set.
- R9: Bank line n is high exactly when bit n of the gate register (offset 0x08) is 1 and any pending bit of pins 16n to 16n+15 is set.
- R10: A pending bit stays set until software clears it, even after the pin returns to its old level. The bank line stays high for as long as the bit is pending.
- R11: Clearing a bank gate bit lowers that bank's line but does not alter the pending bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 32 | Synchronized pin levels |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i (combinational) |
| bank_irq_o | output | 2 | Level interrupt line per 16-pin bank |

## Verification
The table-driven part programs different rising and falling masks and moves the pins between two levels. The patterns include all-rising, all-falling, disjoint rising and falling masks on opposite-moving bytes, no enables at all, and alternating bits with both enables. Each pattern isolates one cause of a latched bit: the transition direction, the enable that matches it, or both together. Directed tests then cover the cases where ordering matters. These are a transition that coincides with an acknowledge, a pending bit that outlives the pin pulse, and gating of one bank while the other stays live.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFS_BANK_EN  = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_RISE_SET = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_RISE_CLR = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_FALL_SET = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_FALL_CLR = 8'h1C;
    localparam logic [ADDR_W-1:0] OFS_STATUS   = 8'h20;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_BANK_EN,
        SEL_RISE_SET,
        SEL_RISE_CLR,
        SEL_FALL_SET,
        SEL_FALL_CLR,
        SEL_STATUS
    } reg_sel_e;

    function automatic reg_sel_e decode_addr(logic [ADDR_W-1:0] a);
        reg_sel_e s;
        case (a)
            OFS_BANK_EN:  s = SEL_BANK_EN;
            OFS_RISE_SET: s = SEL_RISE_SET;
            OFS_RISE_CLR: s = SEL_RISE_CLR;
            OFS_FALL_SET: s = SEL_FALL_SET;
            OFS_FALL_CLR: s = SEL_FALL_CLR;
            OFS_STATUS:   s = SEL_STATUS;
            default:      s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/gei_edge_detect.sv
module gei_edge_detect #(
    parameter int NUM_PINS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_i,
    input  logic [NUM_PINS-1:0] rise_en_i,
    input  logic [NUM_PINS-1:0] fall_en_i,
    output logic [NUM_PINS-1:0] hit_o
);

    typedef struct packed {
        logic [NUM_PINS-1:0] prev;
    } det_state_t;

    det_state_t state_d, state_q;
    logic [NUM_PINS-1:0] went_up, went_down;

    always_comb begin
        state_d      = state_q;
        state_d.prev = pin_i;
        went_up      = pin_i & ~state_q.prev;
        went_down    = ~pin_i & state_q.prev;
        hit_o        = (went_up & rise_en_i) | (went_down & fall_en_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    // R5
    disabled_pin_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((rise_en_i | fall_en_i) == '0) |-> (hit_o == '0));

endmodule

// File: rtl/gei_enable_regs.sv
module gei_enable_regs #(
    parameter int NUM_PINS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                set_we_i,
    input  logic                clr_we_i,
    input  logic [NUM_PINS-1:0] wdata_i,
    output logic [NUM_PINS-1:0] mask_o
);

    typedef struct packed {
        logic [NUM_PINS-1:0] mask;
    } en_state_t;

    en_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (set_we_i) state_d.mask = state_q.mask | wdata_i;
        if (clr_we_i) state_d.mask = state_d.mask & ~wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign mask_o = state_q.mask;

    // R2
    set_bits_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_we_i && !clr_we_i) |=> ((mask_o & $past(wdata_i)) == $past(wdata_i)));

    // R3
    clr_bits_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we_i |=> ((mask_o & $past(wdata_i)) == '0));

    // R2
    idle_mask_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_we_i && !clr_we_i) |=> $stable(mask_o));

endmodule

// File: rtl/gei_status_latch.sv
module gei_status_latch #(
    parameter int NUM_PINS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] hit_i,
    input  logic                ack_we_i,
    input  logic [NUM_PINS-1:0] wdata_i,
    output logic [NUM_PINS-1:0] status_o
);

    typedef struct packed {
        logic [NUM_PINS-1:0] pend;
    } st_state_t;

    st_state_t state_d, state_q;
    logic [NUM_PINS-1:0] ack_mask;

    always_comb begin
        state_d      = state_q;
        ack_mask     = ack_we_i ? wdata_i : '0;
        state_d.pend = (state_q.pend & ~ack_mask) | hit_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign status_o = state_q.pend;

    // R8
    new_hit_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_i != '0) |=> ((status_o & $past(hit_i)) == $past(hit_i)));

    // R10
    pending_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_we_i |=> ((status_o & $past(status_o)) == $past(status_o)));

endmodule

// File: rtl/gei_bank_gate.sv
module gei_bank_gate #(
    parameter int NUM_PINS  = 32,
    parameter int BANK_PINS = 16
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [NUM_PINS-1:0]                status_i,
    input  logic [(NUM_PINS/BANK_PINS)-1:0]    bank_en_i,
    output logic [(NUM_PINS/BANK_PINS)-1:0]    irq_o
);

    localparam int NUM_BANKS = NUM_PINS / BANK_PINS;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic any_pend;
        always_comb begin
            any_pend  = |status_i[b*BANK_PINS +: BANK_PINS];
            irq_o[b]  = any_pend & bank_en_i[b];
        end

        // R11
        gate_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !bank_en_i[b] |-> !irq_o[b]);

        // R9
        line_needs_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq_o[b] |-> (status_i[b*BANK_PINS +: BANK_PINS] != '0));
    end

endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
    import gpio_edge_pkg::*;
#(
    parameter int NUM_PINS  = 32,
    parameter int BANK_PINS = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [31:0]          pin_i,
    input  logic                 reg_we_i,
    input  logic [7:0]           reg_addr_i,
    input  logic [31:0]          reg_wdata_i,
    output logic [31:0]          reg_rdata_o,
    output logic [1:0]           bank_irq_o
);

    localparam int NUM_BANKS = NUM_PINS / BANK_PINS;

    typedef struct packed {
        logic [NUM_BANKS-1:0] bank_en;
    } top_state_t;

    top_state_t state_d, state_q;
    reg_sel_e   sel;

    logic [NUM_PINS-1:0] rise_mask, fall_mask, hits, pend;
    logic rise_set_we, rise_clr_we, fall_set_we, fall_clr_we, ack_we;

    always_comb begin
        sel         = decode_addr(reg_addr_i);
        rise_set_we = reg_we_i && (sel == SEL_RISE_SET);
        rise_clr_we = reg_we_i && (sel == SEL_RISE_CLR);
        fall_set_we = reg_we_i && (sel == SEL_FALL_SET);
        fall_clr_we = reg_we_i && (sel == SEL_FALL_CLR);
        ack_we      = reg_we_i && (sel == SEL_STATUS);

        state_d = state_q;
        if (reg_we_i && (sel == SEL_BANK_EN))
            state_d.bank_en = reg_wdata_i[NUM_BANKS-1:0];

        reg_rdata_o = '0;
        case (sel)
            SEL_BANK_EN:                reg_rdata_o[NUM_BANKS-1:0] = state_q.bank_en;
            SEL_RISE_SET, SEL_RISE_CLR: reg_rdata_o = rise_mask;
            SEL_FALL_SET, SEL_FALL_CLR: reg_rdata_o = fall_mask;
            SEL_STATUS:                 reg_rdata_o = pend;
            default:                    reg_rdata_o = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    gei_enable_regs #(.NUM_PINS(NUM_PINS)) u_rise (
        .clk(clk), .rst_n(rst_n),
        .set_we_i(rise_set_we), .clr_we_i(rise_clr_we),
        .wdata_i(reg_wdata_i), .mask_o(rise_mask)
    );

    gei_enable_regs #(.NUM_PINS(NUM_PINS)) u_fall (
        .clk(clk), .rst_n(rst_n),
        .set_we_i(fall_set_we), .clr_we_i(fall_clr_we),
        .wdata_i(reg_wdata_i), .mask_o(fall_mask)
    );

    gei_edge_detect #(.NUM_PINS(NUM_PINS)) u_det (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i),
        .rise_en_i(rise_mask), .fall_en_i(fall_mask), .hit_o(hits)
    );

    gei_status_latch #(.NUM_PINS(NUM_PINS)) u_stat (
        .clk(clk), .rst_n(rst_n), .hit_i(hits),
        .ack_we_i(ack_we), .wdata_i(reg_wdata_i), .status_o(pend)
    );

    gei_bank_gate #(.NUM_PINS(NUM_PINS), .BANK_PINS(BANK_PINS)) u_gate (
        .clk(clk), .rst_n(rst_n), .status_i(pend),
        .bank_en_i(state_q.bank_en), .irq_o(bank_irq_o)
    );

    // R11
    gate_write_keeps_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we_i && (sel == SEL_BANK_EN) && (hits == '0)) |=> $stable(pend));

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |-> (bank_irq_o == '0 && pend == '0));

endmodule

// File: tb/sim_gpio_edge_irq.sv
`timescale 1ns/1ps
module sim_gpio_edge_irq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pin = '0;
    logic        we = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [1:0]  irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    gpio_edge_irq u0 (
        .clk(clk), .rst_n(rst_n), .pin_i(pin),
        .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .bank_irq_o(irq)
    );

    localparam logic [7:0] A_GATE = 8'h08, A_RS = 8'h10, A_RC = 8'h14,
                           A_FS = 8'h18, A_FC = 8'h1C, A_ST = 8'h20;

    // rise mask, fall mask, pins before, pins after, expected pending
    typedef struct packed {
        logic [31:0] rise, fall, from_v, to_v, exp_v;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{32'hFFFFFFFF, 32'h00000000, 32'h00000000, 32'h0000FFFF, 32'h0000FFFF},
        '{32'h00000000, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0F0F0F0F, 32'hF0F0F0F0},
        '{32'h0000FF00, 32'h00FF0000, 32'h00FF0000, 32'h0000FF00, 32'h00FFFF00},
        '{32'h00000000, 32'h00000000, 32'h00000000, 32'hFFFFFFFF, 32'h00000000},
        '{32'hAAAAAAAA, 32'hAAAAAAAA, 32'hFFFFFFFF, 32'h00000000, 32'hAAAAAAAA},
        '{32'h80000001, 32'h00000000, 32'h80000000, 32'h00000001, 32'h00000001}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic settle(input logic [31:0] p);
        @(negedge clk);
        pin = p;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(A_RS, v);   check("R1 rise mask", v, 32'h0);
        rd(A_FS, v);   check("R1 fall mask", v, 32'h0);
        rd(A_ST, v);   check("R1 pending", v, 32'h0);
        rd(A_GATE, v); check("R1 gate", v, 32'h0);
        check("R1 lines", {30'h0, irq}, 32'h0);

        // R2 set and read back from both offsets; zeros leave bits alone
        wr(A_RS, 32'h0000_00F0);
        wr(A_RS, 32'h0000_0000);
        rd(A_RS, v); check("R2 set read", v, 32'h0000_00F0);
        wr(A_RS, 32'h0001_0000);
        rd(A_RC, v); check("R2 read via clear offset", v, 32'h0001_00F0);
        // R3 partial clear
        wr(A_RC, 32'h0000_0030);
        rd(A_RS, v); check("R3 partial clear", v, 32'h0001_00C0);
        wr(A_RC, 32'hFFFF_FFFF);
        rd(A_RS, v); check("R3 clear all", v, 32'h0);
        // R4 falling pair
        wr(A_FS, 32'h1234_0000);
        rd(A_FC, v); check("R4 fall read via clear", v, 32'h1234_0000);
        wr(A_FC, 32'h1000_0000);
        rd(A_FS, v); check("R4 fall partial clear", v, 32'h0234_0000);
        wr(A_FC, 32'hFFFF_FFFF);

        // R5 / R6 table walk
        foreach (VECS[i]) begin
            wr(A_RC, 32'hFFFF_FFFF);
            wr(A_FC, 32'hFFFF_FFFF);
            settle(VECS[i].from_v);
            wr(A_ST, 32'hFFFF_FFFF);
            wr(A_RS, VECS[i].rise);
            wr(A_FS, VECS[i].fall);
            @(negedge clk);
            pin = VECS[i].to_v;
            rd(A_ST, v);
            check($sformatf("R5 R6 vector %0d", i), v, VECS[i].exp_v);
        end

        // R7 acknowledge: zeros keep, ones clear (pending = AAAA... from last-but-one? use fresh)
        wr(A_RC, 32'hFFFF_FFFF);
        wr(A_FC, 32'hFFFF_FFFF);
        settle(32'h0);
        wr(A_ST, 32'hFFFF_FFFF);
        wr(A_RS, 32'h0000_000F);
        @(negedge clk); pin = 32'h0000_000F;
        rd(A_ST, v); check("R5 low nibble", v, 32'h0000_000F);
        wr(A_ST, 32'h0000_0000);
        rd(A_ST, v); check("R7 zero write keeps", v, 32'h0000_000F);
        wr(A_ST, 32'h0000_0005);
        rd(A_ST, v); check("R7 partial ack", v, 32'h0000_000A);
        wr(A_ST, 32'hFFFF_FFFF);

        // R8 edge and ack at the same clock edge
        settle(32'h0);
        wr(A_ST, 32'hFFFF_FFFF);
        @(negedge clk);
        pin = 32'h0000_0001; we = 1'b1; addr = A_ST; wdata = 32'h0000_0001;
        @(negedge clk);
        we = 1'b0;
        rd(A_ST, v); check("R8 edge beats ack", v, 32'h0000_0001);

        // R9 / R10 / R11 bank lines
        wr(A_RC, 32'hFFFF_FFFF);
        wr(A_RS, 32'h0010_0008);
        settle(32'h0);
        wr(A_ST, 32'hFFFF_FFFF);
        @(negedge clk); pin = 32'h0000_0008;
        @(negedge clk); pin = 32'h0;
        repeat (2) @(negedge clk);
        check("R9 gate off keeps line low", {30'h0, irq}, 32'h0);
        wr(A_GATE, 32'h3);
        #1 check("R9 bank0 only", {30'h0, irq}, 32'h1);
        rd(A_ST, v); check("R10 pending outlives pulse", v, 32'h0000_0008);
        @(negedge clk); pin = 32'h0010_0000;
        @(negedge clk);
        #1 check("R9 both banks", {30'h0, irq}, 32'h3);
        wr(A_GATE, 32'h2);
        #1 check("R11 bank0 gated", {30'h0, irq}, 32'h2);
        rd(A_ST, v); check("R11 pending unchanged", v, 32'h0010_0008);
        wr(A_ST, 32'h0010_0000);
        #1 check("R10 line drops after ack", {30'h0, irq}, 32'h0);
        wr(A_GATE, 32'h1);
        #1 check("R10 bank0 still pending", {30'h0, irq}, 32'h1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule